// File: doc/BRIEF.md
# System Tick Countdown Timer

This block is a periodic 24-bit down-counter for a processor subsystem. It sits on a simple 32-bit register bus with aligned word accesses. Software programs a reload value and sets an enable bit. The counter then steps down once per timer step and wraps back to the reload value one step after it reaches zero. A step is either every clock cycle or a cycle qualified by an external reference enable. Each natural arrival at zero sets a sticky flag, and it can also raise a one-cycle interrupt request.

The flag is cleared by reading the control/status register. Writing any value to the current-value register forces the count to zero and clears the flag without signalling an interrupt, so the next step reloads the counter. A reload value of zero parks the counter at zero. A debug-halt input freezes counting. A read-only calibration word is also provided.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control/status register (byte offset 0x10) reads 0x00000000, the reload register (0x14) and the current-value register (0x18) read 0, the calibration register (0x1C) reads 0x00000004, and `irq` is low.
- R2: The reload register keeps only bits 23:0 of a write. Reads of the reload and current-value registers return zero in bits 31:24.
- R3: A step happens when ENABLE (bit 0 of control/status) is set. When CLKSOURCE (bit 2) is 1, a step happens on every clock cycle. On each step a nonzero count decrements by one. With ENABLE clear the count holds.
- R4: A step taken at a count of zero loads the reload value. With reload value N > 0 the count repeats with period N+1 steps.
- R5: COUNTFLAG (bit 16 of control/status) is set by a step from 1 to 0. Any read of control/status clears it. When a read and a setting step fall in the same cycle, the read returns the old flag and the flag ends set.
- R6: A write of any data to the current-value register zeroes the count and clears COUNTFLAG. It wins over a step in the same cycle and raises no interrupt. The next step loads the reload value.
- R7: With a reload value of 0 the count stays at 0, and neither COUNTFLAG nor `irq` is raised.
- R8: While `dbg_halt` is high the count does not change.
- R9: With CLKSOURCE = 0, a step happens only in a cycle where `ref_tick` is high.
- R10: When TICKINT (bit 1) is set, a step from 1 to 0 drives `irq` high for exactly the following cycle. When TICKINT is clear, no pulse is produced.
- R11: Writes to the calibration register are ignored. Control/status bits other than 0, 1, 2 and 16 read as 0. Reads of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Bus access in this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address of the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the access cycle |
| ref_tick | input | 1 | External reference step enable |
| dbg_halt | input | 1 | Freeze counting while high |
| irq | output | 1 | One-cycle tick interrupt request |

## Verification
Two pairs of events can land in the same cycle. A control/status read can coincide with the step that takes the count from 1 to 0. A current-value write can coincide with a step. The bench creates both by asserting `ref_tick` in the very cycle it issues the bus access. For the read, it expects the old flag in the returned data and the flag set on the following read. For the write, it expects a zero count, a cleared flag and no `irq` pulse. A free-running sweep over small reload values then compares every cycle's count and `irq` against an arithmetic period model.

// File: rtl/tick_timer_pkg.sv
// Shared constants for the tick timer: register offsets and bit positions.
// Assumes byte addressing with aligned 32-bit word accesses.
package tick_timer_pkg;
    localparam int unsigned OFS_CTRL   = 'h10;
    localparam int unsigned OFS_RELOAD = 'h14;
    localparam int unsigned OFS_COUNT  = 'h18;
    localparam int unsigned OFS_CALIB  = 'h1C;

    localparam int BIT_EN   = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_CLK  = 2;
    localparam int BIT_FLAG = 16;
endpackage

// File: rtl/tick_counter.sv
// Down-counter core. It decrements on each step, loads the reload value on a
// step taken at zero, and is zeroed by a clear request that overrides any step.
// Assumes step and clear are single-cycle qualifiers from the same clock.
module tick_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Natural arrival at zero: a step from one that no clear overrides.
    assign hit = step && !clear && (count == ONE);

    // Count register: clear, wrap to reload, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (step)
            count <= (count == '0) ? reload : count - ONE;
    end
endmodule

// File: rtl/tick_status.sv
// Sticky wrap flag. It is set by a hit and cleared by a status read or a count
// clear; a hit wins over a clear in the same cycle. Assumes hit and clear are
// never both produced by a count clear (the counter gates hit with clear).
module tick_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd_clear,
    input  logic wr_clear,
    output logic flag
);
    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (rd_clear || wr_clear)
            flag <= 1'b0;
    end
endmodule

// File: rtl/tick_timer.sv
// System tick timer top. It decodes the register bus, holds the control and
// reload registers, qualifies steps and drives the interrupt pulse.
// Assumes one access per cycle and aligned word addresses; read data is
// combinational in the access cycle.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int          CNT_W     = 24,
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] CALIB_VAL = 32'h0000_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              ref_tick,
    input  logic              dbg_halt,
    output logic              irq
);
    localparam int PAD_W = 32 - CNT_W;

    logic             hit_ctrl, hit_reload, hit_count, hit_calib;
    logic             ctrl_wr, reload_wr, cvr_wr, ctrl_rd;
    logic             ctl_en, ctl_ie, ctl_clk;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             step, zero_hit, flag;
    logic             unused_wbits;

    // Address decode against the fixed register offsets.
    assign hit_ctrl   = (addr == ADDR_W'(OFS_CTRL));
    assign hit_reload = (addr == ADDR_W'(OFS_RELOAD));
    assign hit_count  = (addr == ADDR_W'(OFS_COUNT));
    assign hit_calib  = (addr == ADDR_W'(OFS_CALIB));

    assign ctrl_wr   = sel &&  wr_en && hit_ctrl;
    assign reload_wr = sel &&  wr_en && hit_reload;
    assign cvr_wr    = sel &&  wr_en && hit_count;
    assign ctrl_rd   = sel && !wr_en && hit_ctrl;

    assign unused_wbits = ^{wdata[31:CNT_W]};

    // Control bits, written as a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en  <= 1'b0;
            ctl_ie  <= 1'b0;
            ctl_clk <= 1'b0;
        end else if (ctrl_wr) begin
            ctl_en  <= wdata[BIT_EN];
            ctl_ie  <= wdata[BIT_IE];
            ctl_clk <= wdata[BIT_CLK];
        end
    end

    // Reload register, low CNT_W bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload <= '0;
        else if (reload_wr)
            reload <= wdata[CNT_W-1:0];
    end

    // Step qualifier: enabled, not halted, and clock source active.
    assign step = ctl_en && !dbg_halt && (ctl_clk || ref_tick);

    tick_counter #(.CNT_W(CNT_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .clear  (cvr_wr),
        .reload (reload),
        .count  (cnt),
        .hit    (zero_hit)
    );

    tick_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (zero_hit),
        .rd_clear (ctrl_rd),
        .wr_clear (cvr_wr),
        .flag     (flag)
    );

    // Interrupt pulse, one cycle after a natural arrival at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= zero_hit && ctl_ie;
    end

    // Read multiplexer; unmapped offsets and writes return zero.
    always_comb begin
        rdata = '0;
        if (sel && !wr_en) begin
            if (hit_ctrl) begin
                rdata[BIT_EN]   = ctl_en;
                rdata[BIT_IE]   = ctl_ie;
                rdata[BIT_CLK]  = ctl_clk;
                rdata[BIT_FLAG] = flag;
            end else if (hit_reload)
                rdata = {{PAD_W{1'b0}}, reload};
            else if (hit_count)
                rdata = {{PAD_W{1'b0}}, cnt};
            else if (hit_calib)
                rdata = CALIB_VAL;
        end
    end
endmodule

// File: rtl/tick_timer_chk.sv
// Property checker for tick_timer, attached by bind. It observes ports and
// the signals passed between the counter, status and decode logic.
module tick_timer_chk #(
    parameter int          CNT_W     = 24,
    parameter int          ADDR_W    = 8,
    parameter logic [31:0] CALIB_VAL = 32'h0000_0004
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              irq,
    input logic              dbg_halt,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload,
    input logic              flag,
    input logic              cvr_wr,
    input logic              ctl_en
);
    // R10: the interrupt lasts one cycle.
    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: a pulse is only seen with the count at zero.
    assert_irq_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == '0));

    // R5: a pulse always comes with the flag set.
    assert_irq_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R6: a count write zeroes the count, clears the flag, no pulse.
    assert_cvr_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cvr_wr |=> (cnt == '0) && !flag && !irq);

    // R8: a halt freezes the count.
    assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !cvr_wr) |=> $stable(cnt));

    // R3: disabled counter holds.
    assert_disabled_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !cvr_wr) |=> $stable(cnt));

    // R7: zero reload keeps the count parked.
    assert_park_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload == '0 && cnt == '0) |=> (cnt == '0) && !irq);

    // R2: count reads carry zero upper bits.
    assert_count_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_en && addr == ADDR_W'('h18)) |-> (rdata[31:CNT_W] == '0));

    // R11: calibration read returns the fixed word.
    assert_calib_const_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_en && addr == ADDR_W'('h1C)) |-> (rdata == CALIB_VAL));
endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CALIB_VAL(CALIB_VAL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata    (rdata),
    .irq      (irq),
    .dbg_halt (dbg_halt),
    .cnt      (cnt),
    .reload   (reload),
    .flag     (flag),
    .cvr_wr   (cvr_wr),
    .ctl_en   (ctl_en)
);

// File: tb/tick_timer_test.sv
// Self-checking bench for tick_timer: directed corner cases in reference-step
// mode, then a free-running sweep over small reload values.
module tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ref_tick = 1'b0, dbg_halt = 1'b0;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] v;

    localparam logic [7:0] A_CSR = 8'h10, A_RVR = 8'h14, A_CVR = 8'h18, A_CAL = 8'h1C;

    always #2.5 clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ref_tick(ref_tick),
        .dbg_halt(dbg_halt), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1'b1; wr_en = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk); sel = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_CSR, v); check("R1 csr", v, 32'h0);
        rd(A_RVR, v); check("R1 rvr", v, 32'h0);
        rd(A_CVR, v); check("R1 cvr", v, 32'h0);
        rd(A_CAL, v); check("R1 calib", v, 32'h4);

        // R2/R4: 24-bit reload and wrap from zero
        wr(A_RVR, 32'hFFFF_FFFF);
        rd(A_RVR, v); check("R2 rvr mask", v, 32'h00FF_FFFF);
        wr(A_CVR, 32'h1234);
        wr(A_CSR, 32'h1);
        tick(); rd(A_CVR, v); check("R4 wrap load", v, 32'h00FF_FFFF);
        tick(); rd(A_CVR, v); check("R3 decrement", v, 32'h00FF_FFFE);
        // R9: idle cycles without ref_tick do not step
        repeat (5) @(negedge clk);
        rd(A_CVR, v); check("R9 gated", v, 32'h00FF_FFFE);
        // R8: halt freezes
        dbg_halt = 1'b1; tick(); tick(); dbg_halt = 1'b0;
        rd(A_CVR, v); check("R8 halt", v, 32'h00FF_FFFE);
        // R3: disabled holds
        wr(A_CSR, 32'h0); tick();
        rd(A_CVR, v); check("R3 disabled", v, 32'h00FF_FFFE);

        // R5/R10: flag and pulse with TICKINT
        wr(A_RVR, 32'h2); wr(A_CVR, 32'h0); wr(A_CSR, 32'h3);
        tick(); check("R10 no irq at reload", {31'b0, irq}, 32'h0);
        tick(); check("R10 no irq at 1", {31'b0, irq}, 32'h0);
        tick(); check("R10 irq at zero", {31'b0, irq}, 32'h1);
        @(negedge clk); check("R10 irq one cycle", {31'b0, irq}, 32'h0);
        rd(A_CSR, v); check("R5 flag set", v, 32'h0001_0003);
        rd(A_CSR, v); check("R5 read clears", v, 32'h0000_0003);

        // R5: read and setting step in the same cycle
        tick(); tick();
        @(negedge clk); sel = 1'b1; wr_en = 1'b0; addr = A_CSR; ref_tick = 1'b1;
        #1 v = rdata;
        @(negedge clk); sel = 1'b0; ref_tick = 1'b0;
        check("R5 coincident read old", v, 32'h0000_0003);
        check("R10 coincident irq", {31'b0, irq}, 32'h1);
        rd(A_CSR, v); check("R5 set wins", v, 32'h0001_0003);

        // R6: count write with a coincident step
        tick(); tick(); tick();
        @(negedge clk); sel = 1'b1; wr_en = 1'b1; addr = A_CVR; wdata = 32'hABCD; ref_tick = 1'b1;
        @(negedge clk); sel = 1'b0; wr_en = 1'b0; ref_tick = 1'b0;
        check("R6 no irq", {31'b0, irq}, 32'h0);
        rd(A_CVR, v); check("R6 zeroed", v, 32'h0);
        rd(A_CSR, v); check("R6 flag cleared", v, 32'h0000_0003);
        tick(); check("R6 reload no irq", {31'b0, irq}, 32'h0);
        rd(A_CVR, v); check("R6 reloads", v, 32'h2);

        // R10: TICKINT clear gives no pulse but flag sets
        wr(A_CSR, 32'h1);
        tick(); tick(); check("R10 masked", {31'b0, irq}, 32'h0);
        rd(A_CSR, v); check("R5 flag masked", v, 32'h0001_0001);

        // R7: zero reload parks
        wr(A_RVR, 32'h0); wr(A_CVR, 32'h0); wr(A_CSR, 32'h3);
        for (int i = 0; i < 3; i++) begin
            tick(); check("R7 no irq", {31'b0, irq}, 32'h0);
        end
        rd(A_CVR, v); check("R7 parked", v, 32'h0);
        rd(A_CSR, v); check("R7 no flag", v, 32'h0000_0003);

        // R11: ignored calib write, reserved and unmapped reads
        wr(A_CAL, 32'hFFFF_FFFF);
        rd(A_CAL, v); check("R11 calib", v, 32'h4);
        rd(8'h20, v); check("R11 unmapped", v, 32'h0);
        wr(A_CSR, 32'hFFFF_FFFF);
        rd(A_CSR, v); check("R11 reserved", v, 32'h0000_0007);
        wr(A_CSR, 32'h0);

        // R3/R4/R10: free-running sweep with CLKSOURCE=1
        for (int r = 0; r <= 6; r++) begin
            wr(A_CSR, 32'h0); wr(A_RVR, r); wr(A_CVR, 32'h0);
            rd(A_CSR, v);
            @(negedge clk); sel = 1'b1; wr_en = 1'b1; addr = A_CSR; wdata = 32'h7;
            @(posedge clk); #1 wr_en = 1'b0; addr = A_CVR;
            @(negedge clk); check("R3 sweep start", rdata, 32'h0);
            for (int k = 1; k <= 3 * (r + 1) + 2; k++) begin
                int exp_v;
                exp_v = (r == 0) ? 0 : r - ((k - 1) % (r + 1));
                @(negedge clk);
                check("R4 sweep count", rdata, exp_v);
                check("R10 sweep irq", {31'b0, irq}, (r != 0 && exp_v == 0) ? 32'h1 : 32'h0);
            end
            sel = 1'b0;
        end
        wr(A_CSR, 32'h0);

        finish_run();
    end
endmodule